// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one DMA channel that moves data between system memory and a single peripheral FIFO. It works through two memory buffers in turn. Each buffer has its own start address and its own beat count. When the channel drains one buffer, it marks that buffer finished and moves straight on to the other one. Software refills the finished buffer while the channel works on its partner, so a stream can run without pause.

Software controls the channel through a 32-bit register port. The control word has two write offsets: one sets bits and one clears bits. The channel takes one beat of work for each peripheral request. For that beat it makes one memory access at the active buffer address and then pulses an acknowledge back to the peripheral. The direction bit decides whether memory is read or written. Done flags, an interrupt line and a byte-residue output report progress.

To stop the channel, software drops the GO bit. The beat in flight runs to its end, and then the HALT status reads back as 1.

Top module: `pingpong_dma_chan`

## Requirements
- R1: After reset, the control word reads 0x00000040 (only HALT, bit 6, is set). The peripheral-address, start and count registers all read 0. irq, mem_req and periph_ack are 0.
- R2: A write at offset 0x00 sets the control bits that are 1 in the data. A write at offset 0x04 clears those bits. Bit 4 (active buffer), bit 6 (HALT), bit 14 and bits 31:24 cannot be written.
- R3: A beat happens when GO (bit 5) is 1, the active buffer is enabled, its count is nonzero and periph_req is high. The beat is one memory access at {count[19:16], start} followed by a single-cycle periph_ack. With direction (bit 12) at 0, memory is read (mem_we=0) and the word goes out on periph_wdata. With direction at 1, periph_rdata is written to memory (mem_we=1). Beats are spaced exactly 3 cycles apart when memory acknowledges at once.
- R4: Each beat lowers the active count (bits 15:0) by 1. It also raises the active start address by the device width in bytes. The width field is bits 10:9: 0 gives 1 byte, 1 gives 2, 2 gives 4, and 3 gives 1.
- R5: When a beat brings the count to 0, the channel sets that buffer's done bit and clears its enable bit. Buffer 0 uses done bit 1 and enable bit 0. Buffer 1 uses done bit 3 and enable bit 2. The channel then toggles the active-buffer bit 4. If the other buffer is enabled, its first beat keeps the normal 3-cycle spacing.
- R6: If the newly active buffer is not enabled, no transfer takes place and GO stays 1. Transfers resume as soon as software sets that buffer's enable bit.
- R7: An enabled active buffer whose count is 0 completes as soon as GO is 1, with no memory access and no peripheral request needed.
- R8: After GO is cleared, the beat in flight still completes. HALT reads 0 while GO is 1 or a beat is in progress, and reads 1 once the channel is idle with GO cleared.
- R9: irq equals interrupt enable (bit 7) AND (done bit 1 OR done bit 3). Clearing the done bits at offset 0x04 drops irq.
- R10: With byte swap (bit 13) set, each moved word is byte-swapped according to the width. At 32-bit width all four bytes are reversed. At 16-bit width the two low bytes are exchanged and the high half is unchanged. At 8-bit width nothing changes.
- R11: residue_bytes equals the active buffer's count multiplied by the device width in bytes.
- R12: periph_addr equals {control bits 23:20, peripheral-address register}.
- R13: The register offsets are: peripheral address 0x08, buffer 0 start 0x0C, buffer 0 count 0x10, buffer 1 start 0x14, buffer 1 count 0x18. Count registers read back bits 19:0 only. Offset 0x04 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 36 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access accepted |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| periph_req | input | 1 | Peripheral asks for one beat |
| periph_ack | output | 1 | One-cycle beat completion to the peripheral |
| periph_addr | output | 36 | Peripheral FIFO address |
| periph_wdata | output | 32 | Data toward the peripheral |
| periph_rdata | input | 32 | Data from the peripheral |
| irq | output | 1 | Buffer-done interrupt |
| residue_bytes | output | 18 | Bytes left in the active buffer |

## Verification
The bench uses the default parameters: a 16-bit count, a 4-bit high address field and an 8-bit register offset. It keeps buffer counts small (0 to 3 beats, plus 10 for the stop case), so every buffer switch, stall and zero-count completion happens within a few dozen cycles. It sweeps all three device widths, both directions and both swap settings. Every memory address and data word is checked against values worked out arithmetically. Separate runs cover the stall-and-resume path and GO being dropped in the middle of a beat.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    localparam int CNT_W = 16;
    localparam int HI_W  = 4;
    localparam int DW    = 32;
    localparam int MW    = 24;
    localparam int MADDR_W = HI_W + DW;
    localparam int RES_W = CNT_W + 2;

    // control-word bit positions
    localparam int B_EN0  = 0;
    localparam int B_DN0  = 1;
    localparam int B_EN1  = 2;
    localparam int B_DN1  = 3;
    localparam int B_AB   = 4;
    localparam int B_GO   = 5;
    localparam int B_HALT = 6;
    localparam int B_IE   = 7;
    localparam int B_WLO  = 9;
    localparam int B_DIR  = 12;
    localparam int B_SWP  = 13;
    localparam int B_PHI  = 20;

    localparam logic [MW-1:0] MODE_SW_MASK = 24'hFF_BFAF;

    // register offsets
    localparam int OFS_MSET = 'h00;
    localparam int OFS_MCLR = 'h04;
    localparam int OFS_PER  = 'h08;
    localparam int OFS_S0   = 'h0C;
    localparam int OFS_C0   = 'h10;
    localparam int OFS_S1   = 'h14;
    localparam int OFS_C1   = 'h18;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_DONE = 2'd2
    } beat_st_e;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    start;
    } buf_desc_t;

    function automatic logic [2:0] width_bytes(input logic [1:0] w);
        case (w)
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [1:0] width_shift(input logic [1:0] w);
        case (w)
            2'd1:    return 2'd1;
            2'd2:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [DW-1:0] lane_swap(input logic [DW-1:0] d,
                                                input logic [1:0] w,
                                                input logic en);
        if (!en) return d;
        case (w)
            2'd2:    return {d[7:0], d[15:8], d[23:16], d[31:24]};
            2'd1:    return {d[31:16], d[7:0], d[15:8]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/ppd_regfile.sv
module ppd_regfile
    import pp_dma_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              step,
    input  logic              finish,
    input  logic              halted,
    output logic [DW-1:0]     rd_data,
    output logic              go,
    output logic              dir,
    output logic              swp,
    output logic [1:0]        wsel,
    output logic              ie,
    output logic              any_done,
    output logic              act_sel,
    output logic              act_en,
    output logic [HI_W-1:0]   per_hi,
    output logic [DW-1:0]     per_base,
    output buf_desc_t         act_desc
);

    logic [MW-1:0] mode_q, mode_d;
    buf_desc_t     desc_q [2];
    logic [DW-1:0] per_q;

    logic set_hit, clr_hit;
    assign set_hit = wr_en && (addr == AW'(OFS_MSET));
    assign clr_hit = wr_en && (addr == AW'(OFS_MCLR));

    assign act_sel  = mode_q[B_AB];
    assign go       = mode_q[B_GO];
    assign dir      = mode_q[B_DIR];
    assign swp      = mode_q[B_SWP];
    assign wsel     = mode_q[B_WLO+1:B_WLO];
    assign ie       = mode_q[B_IE];
    assign any_done = mode_q[B_DN0] | mode_q[B_DN1];
    assign act_en   = act_sel ? mode_q[B_EN1] : mode_q[B_EN0];
    assign per_hi   = mode_q[B_PHI+HI_W-1:B_PHI];
    assign per_base = per_q;
    assign act_desc = desc_q[act_sel];

    // hardware events first, software set/clear on top
    always_comb begin
        mode_d = mode_q;
        if (finish) begin
            if (act_sel) begin
                mode_d[B_DN1] = 1'b1;
                mode_d[B_EN1] = 1'b0;
            end else begin
                mode_d[B_DN0] = 1'b1;
                mode_d[B_EN0] = 1'b0;
            end
            mode_d[B_AB] = ~mode_q[B_AB];
        end
        if (set_hit) mode_d = mode_d | (wr_data[MW-1:0] & MODE_SW_MASK);
        if (clr_hit) mode_d = mode_d & ~(wr_data[MW-1:0] & MODE_SW_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_d;
    end

    always_ff @(posedge clk) begin
        if (rst) per_q <= '0;
        else if (wr_en && addr == AW'(OFS_PER)) per_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        for (int b = 0; b < 2; b++) begin
            if (rst) begin
                desc_q[b] <= '0;
            end else begin
                if (step && (act_sel == 1'(b))) begin
                    desc_q[b].cnt   <= desc_q[b].cnt - 1'b1;
                    desc_q[b].start <= desc_q[b].start + DW'(width_bytes(wsel));
                end
                if (wr_en && addr == AW'(b == 0 ? OFS_S0 : OFS_S1))
                    desc_q[b].start <= wr_data;
                if (wr_en && addr == AW'(b == 0 ? OFS_C0 : OFS_C1)) begin
                    desc_q[b].hi  <= wr_data[CNT_W+HI_W-1:CNT_W];
                    desc_q[b].cnt <= wr_data[CNT_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            AW'(OFS_MSET): begin
                rd_data         = DW'(mode_q);
                rd_data[B_HALT] = halted;
            end
            AW'(OFS_PER): rd_data = per_q;
            AW'(OFS_S0):  rd_data = desc_q[0].start;
            AW'(OFS_C0):  rd_data = DW'({desc_q[0].hi, desc_q[0].cnt});
            AW'(OFS_S1):  rd_data = desc_q[1].start;
            AW'(OFS_C1):  rd_data = DW'({desc_q[1].hi, desc_q[1].cnt});
            default:      rd_data = '0;
        endcase
    end

    // R5
    fin0_chk: assert property (@(posedge clk) disable iff (rst)
        (finish && !mode_q[B_AB] && !wr_en) |=> (mode_q[B_DN0] && !mode_q[B_EN0] && mode_q[B_AB]));

    // R5
    ab_steady_chk: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(mode_q[B_AB]));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en && !mode_q[B_AB] && desc_q[0].cnt != '0)
        |=> desc_q[0].cnt == $past(desc_q[0].cnt) - 1'b1);

endmodule

// File: rtl/ppd_beat_engine.sv
module ppd_beat_engine
    import pp_dma_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic               dir,
    input  logic               swp,
    input  logic [1:0]         wsel,
    input  logic               act_en,
    input  buf_desc_t          act_desc,
    input  logic               periph_req,
    input  logic               mem_ack,
    input  logic [DW-1:0]      mem_rdata,
    input  logic [DW-1:0]      per_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [DW-1:0]      mem_wdata,
    output logic               periph_ack,
    output logic [DW-1:0]      per_wdata,
    output logic               step,
    output logic               finish,
    output logic               busy
);

    beat_st_e      st_q, st_d;
    logic [DW-1:0] data_q;

    assign mem_addr  = {act_desc.hi, act_desc.start};
    assign mem_we    = dir;
    assign mem_wdata = data_q;
    assign per_wdata = data_q;
    assign busy      = (st_q != ST_IDLE);

    always_comb begin
        st_d       = st_q;
        mem_req    = 1'b0;
        periph_ack = 1'b0;
        step       = 1'b0;
        finish     = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (go && act_en) begin
                    if (act_desc.cnt == '0) finish = 1'b1;
                    else if (periph_req)    st_d = ST_MEM;
                end
            end
            ST_MEM: begin
                mem_req = 1'b1;
                if (mem_ack) st_d = ST_DONE;
            end
            ST_DONE: begin
                periph_ack = 1'b1;
                step       = 1'b1;
                finish     = (act_desc.cnt == CNT_W'(1));
                st_d       = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            data_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && st_d == ST_MEM && dir)
                data_q <= lane_swap(per_rdata, wsel, swp);
            if (st_q == ST_MEM && mem_ack && !dir)
                data_q <= lane_swap(mem_rdata, wsel, swp);
        end
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        periph_ack |=> !periph_ack);

    // R3
    ack_after_mem_chk: assert property (@(posedge clk) disable iff (rst)
        periph_ack |-> $past(mem_req && mem_ack));

endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan
    import pp_dma_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [AW-1:0]      reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic               mem_ack,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               periph_req,
    output logic               periph_ack,
    output logic [MADDR_W-1:0] periph_addr,
    output logic [DW-1:0]      periph_wdata,
    input  logic [DW-1:0]      periph_rdata,
    output logic               irq,
    output logic [RES_W-1:0]   residue_bytes
);

    logic        go, dir, swp, ie, any_done, act_sel, act_en;
    logic [1:0]  wsel;
    logic [HI_W-1:0] per_hi;
    logic [DW-1:0]   per_base;
    buf_desc_t   act_desc;
    logic        step, finish, busy, halted;

    assign halted = !go && !busy;

    ppd_regfile #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wr_data  (reg_wdata),
        .step     (step),
        .finish   (finish),
        .halted   (halted),
        .rd_data  (reg_rdata),
        .go       (go),
        .dir      (dir),
        .swp      (swp),
        .wsel     (wsel),
        .ie       (ie),
        .any_done (any_done),
        .act_sel  (act_sel),
        .act_en   (act_en),
        .per_hi   (per_hi),
        .per_base (per_base),
        .act_desc (act_desc)
    );

    ppd_beat_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .dir        (dir),
        .swp        (swp),
        .wsel       (wsel),
        .act_en     (act_en),
        .act_desc   (act_desc),
        .periph_req (periph_req),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .per_rdata  (periph_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .periph_ack (periph_ack),
        .per_wdata  (periph_wdata),
        .step       (step),
        .finish     (finish),
        .busy       (busy)
    );

    assign irq           = ie & any_done;
    assign periph_addr   = {per_hi, per_base};
    assign residue_bytes = RES_W'(act_desc.cnt) << width_shift(wsel);

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_req && !periph_ack));

    // R8
    go_drop_finish_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> periph_ack);

endmodule

// File: tb/pingpong_dma_chan_bench.sv
`timescale 1ns/1ps
module pingpong_dma_chan_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        periph_req = 1'b0;
    logic        periph_ack;
    logic [35:0] periph_addr;
    logic [31:0] periph_wdata, periph_rdata;
    logic        irq;
    logic [17:0] residue_bytes;

    always #2 clk = ~clk;

    assign mem_ack   = mem_req;
    assign mem_rdata = mem_addr[31:0] ^ 32'h5A00_00C3;

    logic [31:0] pcount;
    always @(posedge clk) begin
        if (rst) pcount <= '0;
        else if (periph_ack) pcount <= pcount + 1;
    end
    assign periph_rdata = 32'h1000_0000 + pcount;

    pingpong_dma_chan u_pingpong_dma_chan (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .periph_req(periph_req), .periph_ack(periph_ack),
        .periph_addr(periph_addr), .periph_wdata(periph_wdata),
        .periph_rdata(periph_rdata), .irq(irq), .residue_bytes(residue_bytes)
    );

    // event log
    int          cyc;
    int          n_mem, n_ack;
    logic [35:0] ev_addr [0:15];
    logic        ev_we   [0:15];
    logic [31:0] ev_wd   [0:15];
    int          ev_cyc  [0:15];
    logic [31:0] ev_pd   [0:15];

    always @(posedge clk) cyc <= cyc + 1;
    initial cyc = 0;

    always @(negedge clk) begin
        if (rst) begin
            n_mem = 0;
            n_ack = 0;
        end else begin
            if (mem_req && mem_ack && n_mem < 16) begin
                ev_addr[n_mem] = mem_addr;
                ev_we[n_mem]   = mem_we;
                ev_wd[n_mem]   = mem_wdata;
                ev_cyc[n_mem]  = cyc;
                n_mem = n_mem + 1;
            end
            if (periph_ack && n_ack < 16) begin
                ev_pd[n_ack] = periph_wdata;
                n_ack = n_ack + 1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic do_reset();
        periph_req = 1'b0;
        reg_wr = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_bits(input logic [31:0] m, input string tag);
        logic [31:0] v;
        int n;
        n = 0;
        do begin
            rd(8'h00, v);
            n++;
        end while (((v & m) != m) && n < 500);
        if ((v & m) != m) chk(tag, v & m, m);
    endtask

    function automatic logic [31:0] exp_swap(input logic [31:0] d, input int w, input int s);
        if (s == 0) return d;
        if (w == 2) return {d[7:0], d[15:8], d[23:16], d[31:24]};
        if (w == 1) return {d[31:16], d[7:0], d[15:8]};
        return d;
    endfunction

    function automatic int bytes_of(input int w);
        return (w == 1) ? 2 : (w == 2) ? 4 : 1;
    endfunction

    initial begin : watchdog
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v, mode, s0, ea32;
        logic [35:0] ea;
        int bidx, bb;

        // R1 reset state
        do_reset();
        rd(8'h00, v); chk("R1 mode after reset", v, 32'h40);
        rd(8'h08, v); chk("R1 periph reg", v, 0);
        rd(8'h0C, v); chk("R1 start0", v, 0);
        rd(8'h10, v); chk("R1 count0", v, 0);
        rd(8'h14, v); chk("R1 start1", v, 0);
        rd(8'h18, v); chk("R1 count1", v, 0);
        chk("R1 irq/mem_req/periph_ack", {irq, mem_req, periph_ack}, 0);

        // R2 set/clear semantics, R9 irq
        wr(8'h00, 32'hFFFF_FFDF);
        rd(8'h00, v); chk("R2 set all but GO", v, 32'h00FF_BFCF);
        chk("R9 irq with IE and done", irq, 1);
        wr(8'h04, 32'h0000_F0F0);
        rd(8'h00, v); chk("R2 clear selected", v, 32'h00FF_0F4F);
        chk("R9 irq without IE", irq, 0);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R2 clear all", v, 32'h40);

        // R13 register map
        wr(8'h08, 32'h1111_2222);
        wr(8'h0C, 32'h3333_4444);
        wr(8'h10, 32'hABCD_1234);
        wr(8'h14, 32'h5555_6666);
        wr(8'h18, 32'h0007_0009);
        rd(8'h08, v); chk("R13 periph reg", v, 32'h1111_2222);
        rd(8'h0C, v); chk("R13 start0", v, 32'h3333_4444);
        rd(8'h10, v); chk("R13 count0 masked", v, 32'h000D_1234);
        rd(8'h14, v); chk("R13 start1", v, 32'h5555_6666);
        rd(8'h18, v); chk("R13 count1", v, 32'h0007_0009);
        rd(8'h04, v); chk("R13 clear offset reads 0", v, 0);
        chk("R12 periph_addr low hi", periph_addr, 36'h0_1111_2222);
        wr(8'h00, 32'h00A0_0000);
        chk("R12 periph_addr with hi bits", periph_addr, 36'hA_1111_2222);

        // R11 residue across widths while halted
        do_reset();
        wr(8'h10, 32'd7);
        for (int w = 0; w < 4; w++) begin
            wr(8'h04, 32'h0000_0600);
            wr(8'h00, 32'(w) << 9);
            @(negedge clk);
            chk($sformatf("R11 residue width %0d", w), residue_bytes,
                18'(7 * ((w == 1) ? 2 : (w == 2) ? 4 : 1)));
        end

        // Sweep: width x direction x swap
        for (int w = 0; w < 3; w++) begin
            for (int s = 0; s < 2; s++) begin
                for (int d = 0; d < 2; d++) begin
                    do_reset();
                    s0 = 32'h0000_1000 + 32'(w * 16);
                    wr(8'h08, 32'h2000_0040);
                    wr(8'h0C, s0);
                    wr(8'h10, {12'h0, 4'h3, 16'd3});
                    wr(8'h14, 32'h8000_2000);
                    wr(8'h18, {12'h0, 4'hC, 16'd2});
                    periph_req = 1'b1;
                    mode = (32'h5 << 20) | (32'(s) << 13) | (32'(d) << 12) |
                           (32'(w) << 9) | 32'h80 | 32'h20 | 32'h4 | 32'h1;
                    wr(8'h00, mode);
                    wait_bits(32'h0000_000A, "R5 both buffers done");
                    periph_req = 1'b0;
                    repeat (4) @(negedge clk);
                    chk($sformatf("R5 beat count w%0d s%0d d%0d", w, s, d), n_mem, 5);
                    chk("R3 ack count", n_ack, 5);
                    for (int k = 0; k < 5; k++) begin
                        bb   = (k < 3) ? 0 : 1;
                        bidx = (k < 3) ? k : k - 3;
                        ea32 = (bb == 0 ? s0 : 32'h8000_2000) + 32'(bidx * bytes_of(w));
                        ea   = {(bb == 0) ? 4'h3 : 4'hC, ea32};
                        chk($sformatf("R4 beat %0d address", k), ev_addr[k], ea);
                        chk($sformatf("R3 beat %0d direction", k), ev_we[k], d[0]);
                        if (d == 0)
                            chk($sformatf("R10 beat %0d data to periph", k), ev_pd[k],
                                exp_swap(ea32 ^ 32'h5A00_00C3, w, s));
                        else
                            chk($sformatf("R10 beat %0d data to memory", k), ev_wd[k],
                                exp_swap(32'h1000_0000 + 32'(k), w, s));
                        if (k > 0)
                            chk($sformatf("R5 beat %0d spacing", k), ev_cyc[k] - ev_cyc[k-1], 3);
                    end
                    rd(8'h00, v);
                    chk("R5 mode after both buffers", v, (mode & ~32'h5) | 32'hA);
                    chk("R9 irq after done", irq, 1);
                    chk("R12 periph_addr", periph_addr, 36'h5_2000_0040);
                    chk("R11 residue zero", residue_bytes, 0);
                    rd(8'h0C, v);
                    chk("R4 start0 advanced", v, s0 + 32'(3 * bytes_of(w)));
                end
            end
        end

        // R6 stall on disabled buffer, then resume
        do_reset();
        wr(8'h0C, 32'h100);
        wr(8'h10, 32'd2);
        wr(8'h14, 32'h200);
        wr(8'h18, 32'd3);
        periph_req = 1'b1;
        wr(8'h00, 32'h0000_04A1);
        wait_bits(32'h2, "R6 buffer0 done");
        repeat (20) @(negedge clk);
        chk("R6 no beats while stalled", n_mem, 2);
        rd(8'h00, v); chk("R6 GO kept, AB=1, halt 0", v, 32'h0000_04B2);
        chk("R11 residue of buffer1", residue_bytes, 18'd12);
        chk("R9 irq on done0", irq, 1);
        wr(8'h04, 32'h2);
        @(negedge clk);
        chk("R9 irq dropped after done clear", irq, 0);
        wr(8'h00, 32'h4);
        wait_bits(32'h8, "R6 buffer1 done");
        periph_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 beats after resume", n_mem, 5);
        chk("R6 first resumed address", ev_addr[2], 36'h0_0000_0200);

        // R7 zero count completes immediately
        do_reset();
        wr(8'h14, 32'h300);
        wr(8'h18, 32'd1);
        wr(8'h00, 32'h0000_0425);
        repeat (4) @(negedge clk);
        rd(8'h00, v); chk("R7 zero-count buffer done", v, 32'h0000_0436);
        chk("R7 no memory access", n_mem, 0);
        periph_req = 1'b1;
        wait_bits(32'h8, "R7 buffer1 done");
        periph_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 single beat", n_mem, 1);
        chk("R7 beat address", ev_addr[0], 36'h0_0000_0300);

        // R8 GO dropped mid-beat
        do_reset();
        wr(8'h0C, 32'h500);
        wr(8'h10, 32'd10);
        wr(8'h00, 32'h21);
        repeat (2) @(negedge clk);
        rd(8'h00, v); chk("R8 halt 0 while GO", v[6], 0);
        periph_req = 1'b1;
        begin
            int n;
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!mem_req && n < 50);
        end
        reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h20;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h00;
        #1;
        chk("R8 beat finishes after GO drop", periph_ack, 1);
        chk("R8 halt 0 during beat", reg_rdata[6], 0);
        @(negedge clk);
        #1;
        chk("R8 halt 1 once idle", reg_rdata[6], 1);
        repeat (10) @(negedge clk);
        periph_req = 1'b0;
        rd(8'h10, v); chk("R8 exactly one beat done", v, 32'd9);
        chk("R8 no further access", n_mem, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule